// File: doc/BRIEF.md
# Beat-Frequency Sweeping PWM Generator

This block produces a pulse-width-modulated output whose frequency is fixed and whose duty cycle sweeps on its own, with no software involvement after setup. Two identical prescaled timers run from the same clock. The "set" timer has the longer period and the "clear" timer is normally one count shorter. Each time the set timer wraps, it drives a one-cycle pulse that sets an S-R latch. Each time the clear timer wraps, it drives a pulse that clears the latch. Because the two pulse trains slip past each other by one timer step per output period, the high time shrinks in equal steps to zero and then starts again from the top. The latch output drives the PWM pin.

An invert input complements the output. This turns the shrinking-duty pattern into a growing one, for example to make a light brighten instead of dim. The prescale and postscale ratios and the counter width are parameters. The two period values are inputs. They should be held constant while the block runs and changed only under reset. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `beat_pwm_sweep`

## Requirements
- R1: Each timer's counter advances once every PRE clock cycles (parameter PRE, default 128); the prescale strobe is never high on two consecutive cycles when PRE > 1.
- R2: A timer with period value P wraps its counter to 0 after P+1 advances, and it emits a one-cycle pulse on every POST-th wrap (parameter POST, default 2). The first pulse appears right after clock edge PRE*(P+1)*POST counted from reset release, and later pulses follow at that same spacing.
- R3: A set pulse with no clear pulse in the same cycle drives the latch to 1 on the next clock edge.
- R4: A clear pulse drives the latch to 0 on the next clock edge, and this also holds when a set pulse arrives in the same cycle (clear dominates).
- R5: With neither pulse present, the latch keeps its value.
- R6: With the clear period one below the set period, the high time in successive output periods shrinks by PRE*POST clock cycles each period. After the window in which it reaches zero, it returns to its largest value.
- R7: pwm_out equals the latch value when invert is 0 and its complement when invert is 1, and it follows a change of invert in the same cycle.
- R8: While rst_n is low, the latch and both timers are cleared, so pwm_out equals invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both timers and the latch |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_period | input | PW | Period value of the set timer (default 0xFF) |
| clr_period | input | PW | Period value of the clear timer (default 0xFE) |
| invert | input | 1 | 1 complements the output |
| pwm_out | output | 1 | Swept-duty PWM output |

## Verification
On every cycle, assertions check the prescale strobe spacing, that a timer pulse only appears as its counter restarts, and the latch's set, clear-dominant and hold transitions. The bench's own reference model drives the checks on output timing, which compare the output with that model on every clock. The step-by-step shrinking of the duty cycle and its wrap back to full width can only be seen over many output periods. So can the behaviour under equal periods, the live inversion and reset in the middle of a run. Only the bench's scenarios exercise these.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  // pulses entering the latch stage
  typedef struct packed {
    logic set;
    logic clr;
  } latch_req_t;

  function automatic int safe_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bpw_timer.sv
module bpw_timer #(
  parameter int PRE  = 128,
  parameter int POST = 2,
  parameter int PW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          pulse
);
  localparam int PREW  = bpw_pkg::safe_width(PRE);
  localparam int POSTW = bpw_pkg::safe_width(POST);

  logic          tick;
  logic          wrap;
  logic          emit;
  logic [PW-1:0] cnt;

  generate
    if (PRE == 1) begin : g_nopre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PREW-1:0] pre_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt <= '0;
        else if (pre_cnt == PREW'(PRE - 1)) pre_cnt <= '0;
        else pre_cnt <= pre_cnt + 1'b1;
      end
      assign tick = (pre_cnt == PREW'(PRE - 1));

      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  assign wrap = tick && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  generate
    if (POST == 1) begin : g_nopost
      assign emit = wrap;
    end else begin : g_post
      logic [POSTW-1:0] post_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) post_cnt <= '0;
        else if (wrap) post_cnt <= (post_cnt == POSTW'(POST - 1)) ? '0 : post_cnt + 1'b1;
      end
      assign emit = wrap && (post_cnt == POSTW'(POST - 1));

      // R2
      post_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (post_cnt == '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else pulse <= emit;
  end

  // R2
  pulse_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cnt == '0));
endmodule

// File: rtl/bpw_srlatch.sv
module bpw_srlatch (
  input  logic                clk,
  input  logic                rst_n,
  input  bpw_pkg::latch_req_t req,
  output logic                q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (req.clr) q <= 1'b0;
    else if (req.set) q <= 1'b1;
  end

  // R3
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.set && !req.clr) |=> q);

  // R4
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req.clr |=> !q);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req.set && !req.clr) |=> $stable(q));
endmodule

// File: rtl/beat_pwm_sweep.sv
module beat_pwm_sweep #(
  parameter int PRE  = 128,
  parameter int POST = 2,
  parameter int PW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] set_period,
  input  logic [PW-1:0] clr_period,
  input  logic          invert,
  output logic          pwm_out
);
  bpw_pkg::latch_req_t req;
  logic                q;

  bpw_timer #(.PRE(PRE), .POST(POST), .PW(PW)) u_set_tmr (
    .clk(clk), .rst_n(rst_n), .period(set_period), .pulse(req.set)
  );

  bpw_timer #(.PRE(PRE), .POST(POST), .PW(PW)) u_clr_tmr (
    .clk(clk), .rst_n(rst_n), .period(clr_period), .pulse(req.clr)
  );

  bpw_srlatch u_latch (
    .clk(clk), .rst_n(rst_n), .req(req), .q(q)
  );

  assign pwm_out = q ^ invert;
endmodule

// File: tb/beat_pwm_sweep_test.sv
module beat_pwm_sweep_test;
  localparam int PRE  = 2;
  localparam int POST = 2;
  localparam int PW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] set_period = 4'd7;
  logic [PW-1:0] clr_period = 4'd6;
  logic          invert = 1'b0;
  logic          pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int m_edge = 0;
  bit m_q = 1'b0;
  bit m_set_hit = 1'b0;
  bit m_clr_hit = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  beat_pwm_sweep #(.PRE(PRE), .POST(POST), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .set_period(set_period), .clr_period(clr_period),
    .invert(invert), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, actual, expected, $time);
    end
  endtask

  // behavioural model: pulse after edge e when e is a positive multiple of the
  // timer spacing; the latch reacts one edge later (R1, R2, R3, R4, R5)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edge = 0;
      m_q = 1'b0;
      m_set_hit = 1'b0;
      m_clr_hit = 1'b0;
    end else begin
      int ts;
      int tr;
      int prev;
      ts = PRE * (int'(set_period) + 1) * POST;
      tr = PRE * (int'(clr_period) + 1) * POST;
      m_edge = m_edge + 1;
      prev = m_edge - 1;
      m_set_hit = (prev > 0) && (prev % ts == 0);
      m_clr_hit = (prev > 0) && (prev % tr == 0);
      if (m_clr_hit) m_q = 1'b0;
      else if (m_set_hit) m_q = 1'b1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      string tag;
      if (m_clr_hit && m_set_hit) tag = "R4 clear dominates";
      else if (m_clr_hit) tag = "R4 clear";
      else if (m_set_hit) tag = "R3 set";
      else if (invert) tag = "R7 inverted hold R5";
      else tag = "R5 hold R1 R2 timing";
      check(tag, pwm_out, m_q ^ invert);
    end
  end

  // R6: high cycles per output period measured at the pin
  task automatic duty_scan(input int nwin);
    int ts;
    int tr;
    ts = PRE * (int'(set_period) + 1) * POST;
    tr = PRE * (int'(clr_period) + 1) * POST;
    for (int k = 0; k <= nwin; k++) begin
      int hi;
      int nxt;
      int exp_hi;
      hi = 0;
      for (int c = 0; c < ts; c++) begin
        @(negedge clk);
        if (pwm_out) hi++;
      end
      nxt = ((k * ts + tr - 1) / tr) * tr;
      exp_hi = nxt - k * ts;
      checks++;
      if (hi != exp_hi) begin
        failures++;
        $display("FAIL R6 window %0d high actual=%0d expected=%0d", k, hi, exp_hi);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state, both invert settings
    check("R8 reset inv0", pwm_out, 1'b0);
    invert = 1'b1;
    #1 check("R8 reset inv1", pwm_out, 1'b1);
    invert = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // sweep 24,20,...,0 then back to 24 (R6)
    duty_scan(9);

    // live inversion changes (R7)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      invert = (i % 7) < 3;
      #1 check("R7 same-cycle invert", pwm_out, m_q ^ invert);
    end
    invert = 1'b0;

    // reset mid-run (R8)
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R8 mid-run reset", pwm_out, 1'b0);
    set_period = 4'd3;
    clr_period = 4'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // equal periods: every set meets a clear, output stays 0 (R4)
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      check("R4 equal periods", pwm_out, 1'b0);
    end

    @(negedge clk);
    rst_n = 1'b0;
    set_period = 4'd5;
    clr_period = 4'd4;
    invert = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset inverted", pwm_out, 1'b1);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);

    // second sweep with non-default periods (R6), invert off
    rst_n = 1'b0;
    invert = 1'b0;
    set_period = 4'd9;
    clr_period = 4'd8;
    @(negedge clk);
    rst_n = 1'b1;
    duty_scan(11);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule